// File: doc/BRIEF.md
# Read-Before-Write Bus Cycle Sequencer

This block performs the memory bus cycles for one instruction of a 16-bit processor whose general registers are held in external RAM rather than in a register file. A pulse on `start` captures an instruction class, the program counter, the workspace base, a register index and two operand addresses. The block then runs a fixed sequence of single-clock accesses on a 16-bit, zero-wait-state memory port. It captures the words it reads and presents them on its result outputs. Decode, arithmetic and flags belong elsewhere. For the class that needs a computed result, the value comes in on `ext_result`.

The two move classes have a byte form. Both of them read the destination word before they write it, and this holds for the full-word move as well. For a byte move, the chosen byte of the source word is merged into the destination word that was just read, and the other byte is written back unchanged. Load-immediate has no byte form, so it writes its register without reading it first. A register n sits at workspace base + 2·n. The memory port has no back-pressure. Every access completes in the clock in which its strobe is high, so the port carries plain strobes and not a valid/ready handshake. `start` is honoured only while the block is idle.

Top module: `rbw_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low, and they stay low until a start is accepted.
- R2: Class 0 (word move) makes exactly four accesses on consecutive clocks: read at PC, read at `src_addr`, read at `dst_addr`, then write to `dst_addr`. The write data is the source word, and the write address equals the address of the read just before it.
- R3: Class 1 (byte move) uses the same four-access order as class 0. The source byte is the high byte when `src_addr[0]`=0 and the low byte when it is 1. The byte is written into the high half of the destination word when `dst_addr[0]`=0 and into the low half when it is 1. The other half keeps the value it was read with.
- R4: Class 2 (load immediate) makes exactly three accesses: read at PC, read at PC+2, then write the immediate word to workspace base + 2·`reg_sel`. It does no read of the register.
- R5: Class 3 (immediate operation) makes four accesses: read at PC, read at PC+2, read at workspace base + 2·`reg_sel`, then write `ext_result` to that same register address.
- R6: Bit 0 of `mem_addr` is 0 for every access. A byte position is expressed only through the merge.
- R7: The first access occurs in the clock after `start` is accepted. `busy` is high in every access clock. `done` is high for one clock, in the clock after the write, and `busy` is low in that clock.
- R8: A `start` that arrives while `busy` is high has no effect: the running sequence is unchanged and no extra sequence follows. A `start` in the `done` clock is accepted.
- R9: At `done`, `instr_word` holds the word read at PC, and `opnd_word` holds the source word (classes 0 and 1) or the immediate word (classes 2 and 3). `dst_word` holds the destination word read (classes 0, 1 and 3).
- R10: `mem_rd` and `mem_wr` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (honoured when idle) |
| op_cls | input | 2 | Class: 0 word move, 1 byte move, 2 load immediate, 3 immediate operation |
| pc | input | 16 | Address of the instruction word |
| wp | input | 16 | Workspace base address |
| reg_sel | input | 4 | Register index for classes 2 and 3 |
| src_addr | input | 16 | Source operand address (bit 0 picks the byte) |
| dst_addr | input | 16 | Destination operand address (bit 0 picks the byte) |
| ext_result | input | 16 | Write value for class 3, held stable while busy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse after the final write |
| mem_addr | output | 16 | Memory word address (bit 0 always 0) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the strobe clock |
| instr_word | output | 16 | Captured instruction word |
| opnd_word | output | 16 | Captured source or immediate word |
| dst_word | output | 16 | Captured destination word |

## Verification
The two functions that can meet in one clock are the acceptance of a new start and the end of the running sequence. A start may arrive in the write clock, where it must be dropped. It may instead arrive in the `done` clock, where it must launch the next sequence. The bench provokes the first case by pulsing `start` with a different class during the fetch and the write clocks. It then checks that the bus trace matches the original class alone and that the port stays silent afterwards. It provokes the second case by issuing a new operation in the very clock that `done` is observed, and it checks that the second trace begins one clock later with the right accesses.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  typedef enum logic [1:0] {
    CLS_MOVW  = 2'd0,
    CLS_MOVB  = 2'd1,
    CLS_LI    = 2'd2,
    CLS_IMMOP = 2'd3
  } op_cls_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_OPND  = 3'd2,
    PH_DRD   = 3'd3,
    PH_WR    = 3'd4
  } phase_e;

  // classes whose destination is read before it is written
  function automatic logic reads_dest(op_cls_e c);
    return c != CLS_LI;
  endfunction

  // classes whose second word is the immediate at PC+2
  function automatic logic uses_imm(op_cls_e c);
    return (c == CLS_LI) || (c == CLS_IMMOP);
  endfunction
endpackage

// File: rtl/rbw_ctrl.sv
module rbw_ctrl
  import rbw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  op_cls_e cls_in,
  output logic    accept,
  output phase_e  ph,
  output op_cls_e cls_q,
  output logic    busy,
  output logic    done,
  output logic    rd_stb,
  output logic    wr_stb
);
  phase_e ph_nx;
  logic   done_q;

  assign accept = start && (ph == PH_IDLE);
  assign busy   = (ph != PH_IDLE);
  assign done   = done_q;
  assign rd_stb = (ph == PH_FETCH) || (ph == PH_OPND) || (ph == PH_DRD);
  assign wr_stb = (ph == PH_WR);

  always_comb begin
    ph_nx = ph;
    unique case (ph)
      PH_IDLE:  if (accept) ph_nx = PH_FETCH;
      PH_FETCH: ph_nx = PH_OPND;
      PH_OPND:  ph_nx = reads_dest(cls_q) ? PH_DRD : PH_WR;
      PH_DRD:   ph_nx = PH_WR;
      PH_WR:    ph_nx = PH_IDLE;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cls_q  <= CLS_MOVW;
      done_q <= 1'b0;
    end else begin
      ph     <= ph_nx;
      done_q <= (ph == PH_WR);
      if (accept) cls_q <= cls_in;
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cls_q != CLS_LI) |-> $past(ph) == PH_DRD);
  p_li_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cls_q == CLS_LI) |-> $past(ph) == PH_OPND);
  p_done_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ph) == PH_WR) && !busy);
  p_hold_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph != PH_WR) |=> $stable(cls_q));
endmodule

// File: rtl/rbw_addr.sv
module rbw_addr
  import rbw_pkg::*;
#(
  parameter int AW   = 16,
  parameter int REGW = 4
) (
  input  phase_e          ph,
  input  op_cls_e         cls_q,
  input  logic [AW-1:0]   pc_q,
  input  logic [AW-1:0]   wp_q,
  input  logic [REGW-1:0] reg_q,
  input  logic [AW-1:0]   src_q,
  input  logic [AW-1:0]   dst_q,
  output logic [AW-1:0]   addr
);
  localparam logic [AW-1:0] WORD_STEP = AW'(2);
  logic [AW-1:0] reg_addr, raw;

  assign reg_addr = wp_q + AW'({reg_q, 1'b0});

  always_comb begin
    unique case (ph)
      PH_FETCH: raw = pc_q;
      PH_OPND:  raw = uses_imm(cls_q) ? pc_q + WORD_STEP : src_q;
      PH_DRD,
      PH_WR:    raw = uses_imm(cls_q) ? reg_addr : dst_q;
      default:  raw = '0;
    endcase
    addr = {raw[AW-1:1], 1'b0};
  end
endmodule

// File: rtl/rbw_merge.sv
module rbw_merge
  import rbw_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_cls_e       cls_q,
  input  logic          src_lo,
  input  logic          dst_lo,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] dest,
  input  logic [DW-1:0] ext,
  output logic [DW-1:0] wdata
);
  localparam int BW = DW / 2;
  logic [BW-1:0] sel_byte;
  logic [DW-1:0] merged;

  assign sel_byte = src_lo ? opnd[BW-1:0] : opnd[DW-1:BW];

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      // half 1 is the high byte (even address), half 0 the low byte (odd)
      localparam logic HALF_LO = (h == 0);
      assign merged[h*BW +: BW] = (dst_lo == HALF_LO) ? sel_byte : dest[h*BW +: BW];
    end
  endgenerate

  always_comb begin
    unique case (cls_q)
      CLS_MOVB:  wdata = merged;
      CLS_IMMOP: wdata = ext;
      default:   wdata = opnd;
    endcase
  end
endmodule

// File: rtl/rbw_seq.sv
module rbw_seq
  import rbw_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int REGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op_cls,
  input  logic [AW-1:0]   pc,
  input  logic [AW-1:0]   wp,
  input  logic [REGW-1:0] reg_sel,
  input  logic [AW-1:0]   src_addr,
  input  logic [AW-1:0]   dst_addr,
  input  logic [DW-1:0]   ext_result,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   instr_word,
  output logic [DW-1:0]   opnd_word,
  output logic [DW-1:0]   dst_word
);
  logic            accept;
  phase_e          ph;
  op_cls_e         cls_q;
  logic [AW-1:0]   pc_q, wp_q, src_q, dst_q;
  logic [REGW-1:0] reg_q;
  logic [DW-1:0]   instr_q, opnd_q, dest_q;

  rbw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cls_in(op_cls_e'(op_cls)),
    .accept(accept), .ph(ph), .cls_q(cls_q), .busy(busy), .done(done),
    .rd_stb(mem_rd), .wr_stb(mem_wr)
  );

  rbw_addr #(.AW(AW), .REGW(REGW)) u_addr (
    .ph(ph), .cls_q(cls_q), .pc_q(pc_q), .wp_q(wp_q), .reg_q(reg_q),
    .src_q(src_q), .dst_q(dst_q), .addr(mem_addr)
  );

  rbw_merge #(.DW(DW)) u_merge (
    .cls_q(cls_q), .src_lo(src_q[0]), .dst_lo(dst_q[0]), .opnd(opnd_q),
    .dest(dest_q), .ext(ext_result), .wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      wp_q    <= '0;
      reg_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      instr_q <= '0;
      opnd_q  <= '0;
      dest_q  <= '0;
    end else begin
      if (accept) begin
        pc_q  <= pc;
        wp_q  <= wp;
        reg_q <= reg_sel;
        src_q <= src_addr;
        dst_q <= dst_addr;
      end
      if (ph == PH_FETCH) instr_q <= mem_rdata;
      if (ph == PH_OPND)  opnd_q  <= mem_rdata;
      if (ph == PH_DRD)   dest_q  <= mem_rdata;
    end
  end

  assign instr_word = instr_q;
  assign opnd_word  = opnd_q;
  assign dst_word   = dest_q;

  p_same_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cls_q != CLS_LI) |-> mem_addr == $past(mem_addr));
  p_even_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !mem_addr[0]);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr));
endmodule

// File: tb/rbw_seq_bench.sv
module rbw_seq_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [1:0]  op_cls;
  logic [15:0] pc, wp, src_addr, dst_addr, ext_result;
  logic [3:0]  reg_sel;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, instr_word, opnd_word, dst_word;
  logic [15:0] mem [0:255];
  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  rbw_seq u_rbw_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cls(op_cls), .pc(pc), .wp(wp),
    .reg_sel(reg_sel), .src_addr(src_addr), .dst_addr(dst_addr),
    .ext_result(ext_result), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .instr_word(instr_word), .opnd_word(opnd_word),
    .dst_word(dst_word)
  );

  assign mem_rdata = mem[mem_addr[8:1]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[8:1]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ev(input logic [15:0] a);
    return {a[15:1], 1'b0};
  endfunction

  // glitch >= 0: pulse start (other class) after that access index
  task automatic run_op(input logic [1:0] c, input logic [15:0] p, input logic [15:0] w,
                        input logic [3:0] r, input logic [15:0] sa, input logic [15:0] da,
                        input logic [15:0] x, input int glitch);
    logic [15:0] snap [0:255];
    logic [15:0] e_addr [4];
    bit          e_wr [4];
    logic [15:0] a_addr [4];
    bit          a_wr [4];
    logic [15:0] e_wd, a_wd, e_in, e_op, e_dw, ra, sw, dw;
    logic [7:0]  b;
    int e_n, k, cyc;
    bit got;
    string rq;
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    ra = w + {11'd0, r, 1'b0};
    e_in = snap[p[8:1]];
    e_addr[0] = ev(p); e_wr[0] = 0;
    rq = (c == 2'd0) ? "R2" : (c == 2'd1) ? "R3" : (c == 2'd2) ? "R4" : "R5";
    if (c <= 2'd1) begin
      sw = snap[sa[8:1]]; dw = snap[da[8:1]];
      e_n = 4; e_op = sw; e_dw = dw;
      e_addr[1] = ev(sa); e_wr[1] = 0;
      e_addr[2] = ev(da); e_wr[2] = 0;
      e_addr[3] = ev(da); e_wr[3] = 1;
      b = sa[0] ? sw[7:0] : sw[15:8];
      e_wd = (c == 2'd0) ? sw : (da[0] ? {dw[15:8], b} : {b, dw[7:0]});
    end else begin
      e_op = snap[(p + 16'd2) >> 1 & 16'h00FF];
      e_addr[1] = ev(p + 16'd2); e_wr[1] = 0;
      if (c == 2'd2) begin
        e_n = 3; e_dw = 16'h0; e_wd = e_op;
        e_addr[2] = ev(ra); e_wr[2] = 1;
      end else begin
        e_n = 4; e_dw = snap[ra[8:1]]; e_wd = x;
        e_addr[2] = ev(ra); e_wr[2] = 0;
        e_addr[3] = ev(ra); e_wr[3] = 1;
      end
    end
    op_cls = c; pc = p; wp = w; reg_sel = r; src_addr = sa; dst_addr = da;
    ext_result = x; start = 1'b1;
    k = 0; cyc = 0; got = 0; a_wd = 16'h0;
    while (!got && cyc < 12) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (done) begin
        got = 1;
        chk(!busy && !mem_rd && !mem_wr, "R7 done clock quiet", {15'd0, busy}, 16'd0);
      end else begin
        if (mem_rd || mem_wr) begin
          if (k < 4) begin
            a_addr[k] = mem_addr; a_wr[k] = mem_wr;
            if (mem_wr) a_wd = mem_wdata;
          end
          chk(busy, "R7 busy in access", {15'd0, busy}, 16'd1);
          chk(!(mem_rd && mem_wr), "R10 one strobe", {14'd0, mem_rd, mem_wr}, 16'd0);
          chk(!mem_addr[0], "R6 even address", mem_addr, ev(mem_addr));
          if (k == glitch) begin
            start = 1'b1; op_cls = c ^ 2'd2;
          end
          k++;
        end else
          chk(0, "R7 gap in sequence", 16'd0, 16'd1);
      end
    end
    op_cls = c;
    chk(got, "R7 done seen", {15'd0, got}, 16'd1);
    chk(k == e_n, {rq, " access count"}, 16'(k), 16'(e_n));
    for (int i = 0; i < 4; i++) if (i < e_n && i < k) begin
      chk(a_addr[i] == e_addr[i], {rq, " access addr"}, a_addr[i], e_addr[i]);
      chk(a_wr[i] == e_wr[i], {rq, " access kind"}, {15'd0, a_wr[i]}, {15'd0, e_wr[i]});
    end
    chk(a_wd == e_wd, {rq, " write data"}, a_wd, e_wd);
    chk(instr_word == e_in, "R9 instr_word", instr_word, e_in);
    chk(opnd_word == e_op, "R9 opnd_word", opnd_word, e_op);
    if (c != 2'd2) chk(dst_word == e_dw, "R9 dst_word", dst_word, e_dw);
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!busy && !mem_rd && !mem_wr && !done, req,
          {13'd0, busy, mem_rd, mem_wr}, 16'd0);
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    rst_n = 0; start = 0; op_cls = 0; pc = 0; wp = 0; reg_sel = 0;
    src_addr = 0; dst_addr = 0; ext_result = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 in reset", {14'd0, busy, done}, 16'd0);
    rst_n = 1;
    quiet(3, "R1 idle after reset");

    // directed byte-merge corners: all four address parities
    run_op(2'd1, 16'h0010, 16'h0100, 4'd0, 16'h0040, 16'h0060, 16'h0, -1); quiet(1, "R3 idle");
    run_op(2'd1, 16'h0010, 16'h0100, 4'd0, 16'h0041, 16'h0060, 16'h0, -1); quiet(1, "R3 idle");
    run_op(2'd1, 16'h0010, 16'h0100, 4'd0, 16'h0040, 16'h0061, 16'h0, -1); quiet(1, "R3 idle");
    run_op(2'd1, 16'h0010, 16'h0100, 4'd0, 16'h0041, 16'h0061, 16'h0, -1); quiet(1, "R3 idle");
    // word move with odd addresses: bit 0 ignored
    run_op(2'd0, 16'h0021, 16'h0100, 4'd0, 16'h0073, 16'h0085, 16'h0, -1); quiet(1, "R2 idle");
    // load immediate to top register, odd PC
    run_op(2'd2, 16'h0031, 16'h0180, 4'd15, 16'h0, 16'h0, 16'h0, -1); quiet(1, "R4 idle");
    run_op(2'd3, 16'h0030, 16'h0180, 4'd7, 16'h0, 16'h0, 16'hBEEF, -1); quiet(1, "R5 idle");

    // R8: start during fetch and during final write is ignored
    run_op(2'd0, 16'h0050, 16'h0100, 4'd0, 16'h0090, 16'h00A0, 16'h0, 0);
    quiet(3, "R8 no extra sequence");
    run_op(2'd2, 16'h0052, 16'h0100, 4'd3, 16'h0, 16'h0, 16'h0, 2);
    quiet(3, "R8 no extra sequence");
    // R8: start in the done clock is accepted (back to back)
    run_op(2'd3, 16'h0054, 16'h0120, 4'd2, 16'h0, 16'h0, 16'h1357, -1);
    run_op(2'd1, 16'h0056, 16'h0120, 4'd0, 16'h00B1, 16'h00C0, 16'h0, -1);
    quiet(2, "R8 idle after chain");

    for (int t = 0; t < 60; t++) begin
      logic [1:0] c;
      c = 2'($urandom_range(0, 3));
      run_op(c, 16'($urandom_range(0, 500)), 16'($urandom_range(0, 400) & 16'hFFFE),
             4'($urandom), 16'($urandom_range(0, 511)), 16'($urandom_range(0, 511)),
             16'($urandom), -1);
      if (t % 3 != 0) quiet(1, "R7 idle between ops");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule